// File: doc/BRIEF.md
# Edge-Selectable Wake-Up Interrupt Port

This block watches a small group of external input lines. Each line can be armed to flag a rising edge or a falling edge. A qualifying edge on a line sets that line's bit in a sticky pending register. Software clears that bit by writing a zero to it. The pending register holds the only record of each event; the block has no separate summary pending flag.

The block produces two requests from the same state. The wake-up request is high whenever any pending line is also enabled. It needs no clock edge, so the clock controller can act on it while the main clock is stopped. The interrupt request needs three further conditions: the wake-up condition, the port-level interrupt enable, and the core's global interrupt enable. Software therefore decides whether leaving low power also enters the service routine. With the port enable off, the core simply resumes after the instruction that put it to sleep. With the port enable on, the service routine runs first.

Inputs pass through a synchronizer before edge detection. Software reaches four registers over a small synchronous register bus. Reads are combinational.

Top module: `wkup_port`

## Requirements
- R1: After reset, all four registers read zero, and `irq` and `wake` are low.
- R2: Address 0 is the line enable mask. Address 1 is the polarity mask, where bit value 0 selects a rising edge and 1 selects a falling edge. Address 3 is the control register: bit 0 is the port interrupt enable and the other bits read 0. Each of these reads back what was last written.
- R3: A qualifying edge on a line sets that line's pending bit (address 2). The bit is visible on the third rising clock edge after the line changes. An edge of the opposite direction sets nothing.
- R4: A pending bit stays set until software writes 0 to that bit at address 2. Writing 1 to a pending bit has no effect.
- R5: If a qualifying edge is detected in the same cycle as a write that clears its bit, the bit stays set.
- R6: A pending bit is latched whether or not its line is enabled. The enable mask only gates the requests.
- R7: `wake` is high exactly when some line is both pending and enabled. It does not depend on the port interrupt enable or on `glob_ie`.
- R8: `irq` is high only when the wake-up condition holds, the port enable bit is 1, and `glob_ie` is 1.
- R9: Rewriting the polarity of a line whose level is steady never sets its pending bit.
- R10: A line already high when reset is released does not set its pending bit.
- R11: Lines are independent: an edge on one line sets only that line's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 8 | Asynchronous input lines |
| glob_ie | input | 1 | Global interrupt enable from the core |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench sweeps every line in both polarities and checks that exactly one pending bit appears, on the expected edge. A swapped polarity decode or a crossed bit index would show up as a wrong or missing bit. It lands a clearing write in the very cycle an edge is detected; a design that lets the clear win would drop the event. It flips polarity on a steady high line and holds a line high through reset release. Edge logic that compared against stale history, or that armed too early, would then show phantom pending bits. Finally, it walks through the enable, port-enable and global-enable combinations. A design that tied `wake` to the interrupt gates would fail to wake when the port interrupt is disabled.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

  typedef enum logic [1:0] {
    RA_EN   = 2'd0,
    RA_POL  = 2'd1,
    RA_PEND = 2'd2,
    RA_CTL  = 2'd3
  } reg_addr_e;

  // Edge qualifier: per bit, a rise when pol=0, a fall when pol=1.
  function automatic logic [7:0] qualify8(input logic [7:0] cur,
                                          input logic [7:0] prev,
                                          input logic [7:0] pol);
    logic [7:0] rise;
    logic [7:0] fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return (rise & ~pol) | (fall & pol);
  endfunction

  // Pending update: new hits dominate clears.
  function automatic logic [7:0] next_pend8(input logic [7:0] pend,
                                            input logic [7:0] hit,
                                            input logic [7:0] clr);
    return (pend & ~clr) | hit;
  endfunction

endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
  parameter int NLINES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] d_async,
  output logic [NLINES-1:0] q_sync
);

  logic [NLINES-1:0] stg [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[SYNC_STAGES-1];

endmodule

// File: rtl/wkp_edge.sv
module wkp_edge #(
  parameter int NLINES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] cur,
  input  logic [NLINES-1:0] pol,
  output logic [NLINES-1:0] hit,
  output logic              armed
);

  // History must be filled with real samples before detection arms.
  localparam int WARM_LIM = SYNC_STAGES + 1;
  localparam int CW       = $clog2(WARM_LIM + 1);

  logic [NLINES-1:0] hist;
  logic [CW-1:0]     warm_cnt;
  logic [NLINES-1:0] rise_v;
  logic [NLINES-1:0] fall_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          warm_cnt <= '0;
    else if (warm_cnt != CW'(WARM_LIM))  warm_cnt <= warm_cnt + 1'b1;
  end

  assign armed  = (warm_cnt == CW'(WARM_LIM));
  assign rise_v = cur & ~hist;
  assign fall_v = ~cur & hist;

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      always_comb begin
        if (!armed)      hit[i] = 1'b0;
        else if (pol[i]) hit[i] = fall_v[i];
        else             hit[i] = rise_v[i];
      end
    end
  endgenerate

endmodule

// File: rtl/wkp_regs.sv
module wkp_regs
  import wkp_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [NLINES-1:0] wdata,
  input  logic [NLINES-1:0] hit,
  output logic [NLINES-1:0] rdata,
  output logic [NLINES-1:0] en_q,
  output logic [NLINES-1:0] pol_q,
  output logic [NLINES-1:0] pend_q,
  output logic              pie_q
);

  reg_addr_e         ra;
  logic              wr_en;
  logic              wr_pol;
  logic              wr_pend;
  logic              wr_ctl;
  logic [NLINES-1:0] clr_mask;

  assign ra       = reg_addr_e'(addr);
  assign wr_en    = wr && (ra == RA_EN);
  assign wr_pol   = wr && (ra == RA_POL);
  assign wr_pend  = wr && (ra == RA_PEND);
  assign wr_ctl   = wr && (ra == RA_CTL);
  assign clr_mask = wr_pend ? ~wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      pie_q <= 1'b0;
    end else begin
      if (wr_en)  en_q  <= wdata;
      if (wr_pol) pol_q <= wdata;
      if (wr_ctl) pie_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | hit;
  end

  always_comb begin
    unique case (ra)
      RA_EN:   rdata = en_q;
      RA_POL:  rdata = pol_q;
      RA_PEND: rdata = pend_q;
      RA_CTL:  rdata = {{(NLINES-1){1'b0}}, pie_q};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/wkup_port.sv
module wkup_port #(
  parameter int NLINES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pins,
  input  logic              glob_ie,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic              irq,
  output logic              wake
);

  logic [NLINES-1:0] line_sync;
  logic [NLINES-1:0] edge_hit;
  logic              det_armed;
  logic [NLINES-1:0] en_q;
  logic [NLINES-1:0] pol_q;
  logic [NLINES-1:0] pend_q;
  logic              pie_q;
  logic [NLINES-1:0] live_src;

  wkp_sync #(.NLINES(NLINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins),
    .q_sync  (line_sync)
  );

  wkp_edge #(.NLINES(NLINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (line_sync),
    .pol   (pol_q),
    .hit   (edge_hit),
    .armed (det_armed)
  );

  wkp_regs #(.NLINES(NLINES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .hit    (edge_hit),
    .rdata  (bus_rdata),
    .en_q   (en_q),
    .pol_q  (pol_q),
    .pend_q (pend_q),
    .pie_q  (pie_q)
  );

  // Combinational so the clock controller can use it with the clock stopped.
  assign live_src = pend_q & en_q;
  assign wake     = |live_src;
  assign irq      = wake & pie_q & glob_ie;

endmodule

// File: rtl/wkup_port_chk.sv
module wkup_port_chk #(
  parameter int NLINES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_ie,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [NLINES-1:0] bus_wdata,
  input logic [NLINES-1:0] edge_hit,
  input logic              det_armed,
  input logic [NLINES-1:0] pend_q,
  input logic              pie_q,
  input logic              irq,
  input logic              wake
);

  logic pend_wr;
  assign pend_wr = bus_wr && (bus_addr == 2'd2);

  // R8: interrupt implies the wake-up condition
  a_r8_irq_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);

  // R8: interrupt gated by both enables
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_ie || !pie_q) |-> !irq);

  // R7: no wake-up without pending state
  a_r7_wake_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !wake);

  // R10: no detection before the history is filled
  a_r10_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !det_armed |-> (edge_hit == '0));

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_bit
      // R3: a detected edge is latched next cycle
      a_r3_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[i] |=> pend_q[i]);
      // R4: pending holds unless a zero is written to it
      a_r4_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !(pend_wr && !bus_wdata[i])) |=> pend_q[i]);
      // R4: a clear without a concurrent hit empties the bit
      a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && !bus_wdata[i] && !edge_hit[i]) |=> !pend_q[i]);
      // R5: a hit during a clear keeps the bit
      a_r5_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && !bus_wdata[i] && edge_hit[i]) |=> pend_q[i]);
    end
  endgenerate

endmodule

bind wkup_port wkup_port_chk #(.NLINES(NLINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glob_ie   (glob_ie),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .edge_hit  (edge_hit),
  .det_armed (det_armed),
  .pend_q    (pend_q),
  .pie_q     (pie_q),
  .irq       (irq),
  .wake      (wake)
);

// File: tb/wkup_port_tb.sv
`timescale 1ns/1ps
module wkup_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       glob_ie = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       wake;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wkup_port u_dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .glob_ie(glob_ie),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  // drive lines, then let sync + detect + latch settle
  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] pin_level);
    @(negedge clk);
    rst_n = 1'b0; pins = pin_level;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(8'h00);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1 reg reset", 2'(a), 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);
    check("R1 wake reset", {7'b0, wake}, 8'h00);

    // R2 readback
    wr_reg(2'd0, 8'hA5); rd_chk("R2 enable rb", 2'd0, 8'hA5);
    wr_reg(2'd1, 8'h3C); rd_chk("R2 polarity rb", 2'd1, 8'h3C);
    wr_reg(2'd3, 8'hFF); rd_chk("R2 control rb", 2'd3, 8'h01);
    wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'h00); wr_reg(2'd3, 8'h00);

    // R3, R6, R11 sweep: each line, each polarity, enable off
    for (int i = 0; i < 8; i++) begin
      logic [7:0] m;
      m = 8'(1 << i);
      // rising
      wr_reg(2'd1, 8'h00);
      drive(m);
      rd_chk("R3 R11 rise sets only own bit", 2'd2, m);
      check("R6 no wake while disabled", {7'b0, wake}, 8'h00);
      wr_reg(2'd2, 8'h00);
      drive(8'h00);
      rd_chk("R3 fall ignored under rise pol", 2'd2, 8'h00);
      // falling
      wr_reg(2'd1, m);
      drive(m);
      rd_chk("R3 rise ignored under fall pol", 2'd2, 8'h00);
      drive(8'h00);
      rd_chk("R3 R11 fall sets only own bit", 2'd2, m);
      wr_reg(2'd2, 8'h00);
    end
    wr_reg(2'd1, 8'h00);

    // R3 latency: visible at 3rd edge, not earlier
    @(negedge clk); pins = 8'h01; bus_addr = 2'd2;
    @(negedge clk); @(negedge clk); #0.5;
    check("R3 not yet after 2 edges", bus_rdata, 8'h00);
    @(negedge clk); #0.5;
    check("R3 set after 3 edges", bus_rdata, 8'h01);

    // R4: writing 1 keeps, writing 0 clears
    wr_reg(2'd2, 8'hFF); rd_chk("R4 write one keeps", 2'd2, 8'h01);
    wr_reg(2'd2, 8'hFE); rd_chk("R4 write zero clears", 2'd2, 8'h00);

    // R5: re-set bit 0 then clear exactly in the detect cycle of a new edge
    drive(8'h00);
    drive(8'h01);
    drive(8'h00);
    @(negedge clk); pins = 8'h01;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
    @(negedge clk); bus_wr = 1'b0;
    rd_chk("R5 edge beats clear", 2'd2, 8'h01);
    wr_reg(2'd2, 8'h00);
    rd_chk("R5 clear alone works", 2'd2, 8'h00);

    // R9: steady high line 0, flip polarity both ways
    wr_reg(2'd1, 8'hFF); repeat (3) @(negedge clk);
    wr_reg(2'd1, 8'h00); repeat (3) @(negedge clk);
    rd_chk("R9 polarity flip sets nothing", 2'd2, 8'h00);
    drive(8'h00);

    // R7 / R8 gating matrix on line 2
    drive(8'h04);
    for (int c = 0; c < 8; c++) begin
      logic en, pie, gie;
      en = c[0]; pie = c[1]; gie = c[2];
      wr_reg(2'd0, en ? 8'h04 : 8'h00);
      wr_reg(2'd3, {7'b0, pie});
      @(negedge clk); glob_ie = gie; #0.5;
      check("R7 wake gating", {7'b0, wake}, {7'b0, en});
      check("R8 irq gating", {7'b0, irq}, {7'b0, en & pie & gie});
    end
    wr_reg(2'd2, 8'h00);
    @(negedge clk); #0.5;
    check("R7 wake drops after clear", {7'b0, wake}, 8'h00);
    glob_ie = 1'b0;

    // R10: line held high across reset release
    do_reset(8'h81);
    rd_chk("R10 no pend from reset level", 2'd2, 8'h00);
    drive(8'h00);
    rd_chk("R10 fall ignored after reset", 2'd2, 8'h00);
    drive(8'h80);
    rd_chk("R10 later edge still seen", 2'd2, 8'h80);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule